// File: doc/BRIEF.md
# Grouped Priority Round-Robin Arbiter

This block decides which of several masters may use one shared bus target. Each master presents a request line and a 2-bit priority value. Among the masters requesting in a cycle, only those holding the numerically smallest priority value compete. Inside that group, the grant rotates round-robin. Each priority value keeps its own rotation pointer, so the fairness of one group does not disturb another.

A mode input sets the arbitration granularity. In beat mode the block arbitrates again after every transfer beat, so a more urgent master can take the bus in the middle of another master's burst. In burst mode, the first beat of a multi-beat burst locks the grant to its owner. The lock holds, whatever the requests and priorities do, until the beat marked last completes. The granted master reports each completed beat on a beat-valid line and marks the final beat of a burst on a beat-last line. The grant is combinational from registered state, and it is one-hot.

Priority inputs pass through a per-master register. This register only loads at clock edges after which no burst is held. A priority change can therefore never alter a burst that is in progress.

Top module: `grp_rr_arbiter`

## Requirements
- R1: Reset sets every held priority to 3 (the lowest), every group pointer to master 0 and clears any burst lock. In the first cycle after reset, all requesters therefore form one group, and master 0 wins if it requests.
- R2: The grant is one-hot or all zeros. It is all zeros when no master requests and no burst is held.
- R3: Priority value 0 is the most urgent and 3 the least. Outside a held burst, only requesters whose held priority equals the smallest held priority among current requesters may be granted.
- R4: Among eligible requesters of priority group p, the grant goes to the first one found by scanning upward (with wrap) from the index in pointer p. When a grant completes, pointer p moves to the winner's index plus one, wrapping from N-1 to 0.
- R5: With burstMode=0, every beat with beatValid=1 while a grant is out completes that grant. Arbitration is redone in the next cycle, and no lock forms.
- R6: With burstMode=1, a beat with beatValid=1 and beatLast=0 locks the grant to that master. The grant stays unchanged regardless of requests or priorities until a beat with beatValid=1 and beatLast=1. Arbitration resumes in the cycle after that beat.
- R7: In burst mode, a first beat that already carries beatLast=1 completes the grant without forming a lock.
- R8: The held priority of master i loads bits [2i+1:2i] of prioVec at every clock edge after which no burst is held, and it governs from the following cycle. During a held burst the held values do not change.
- R9: beatValid=1 in a cycle with an all-zero grant changes no pointer and no lock.
- R10: A cycle with a grant but beatValid=0 changes no pointer, so the same master stays granted while inputs are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| reqVec | input | N | Request line per master |
| prioVec | input | N*PRIO_W | Priority per master, master i in bits [PRIO_W*i +: PRIO_W] |
| burstMode | input | 1 | 1: lock the grant per burst, 0: arbitrate per beat |
| beatValid | input | 1 | The granted master completes a beat this cycle |
| beatLast | input | 1 | The completing beat is the last of its burst |
| grant | output | N | One-hot grant, all zeros when idle |

## Verification
A round-robin pointer that is updated wrongly causes no visible error at first. It shows up only at the next contested arbitration inside that group, which may come many cycles later. For that reason, the random stimulus keeps several masters at equal priority and checks every single cycle. A wrongly held or dropped lock shows in the very next cycle: the grant then moves during a burst, or it sticks after the last beat. A priority register loaded at the wrong time shows one cycle after the change of prioVec, as a winner from the wrong group. The directed sequences change priorities inside held bursts so that this case is exercised.

// File: rtl/arb_pkg.sv
package arb_pkg;
  typedef struct packed {
    logic loadPrio;  // sample priority inputs at this edge
    logic advance;   // a grant completes at this edge
    logic hold;      // a burst lock is currently held
  } ctrlStrobe_t;
endpackage

// File: rtl/arbCtrl.sv
module arbCtrl
  import arb_pkg::*;
#(
  parameter int N = 4,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             burstMode,
  input  logic             beatValid,
  input  logic             beatLast,
  input  logic             anyGrant,
  input  logic [IDX_W-1:0] winIdx,
  output ctrlStrobe_t      strobe,
  output logic [IDX_W-1:0] holdIdx
);
  logic             lockQ;
  logic [IDX_W-1:0] lockIdxQ;
  logic             fire, lastBeat, lockNext;

  always_comb begin
    fire     = beatValid & anyGrant;             // R9: no grant, no effect
    lastBeat = fire & beatLast;
    lockNext = lockQ ? ~lastBeat : (fire & burstMode & ~beatLast);
    strobe.hold     = lockQ;
    strobe.advance  = lockQ ? lastBeat : (fire & ~(burstMode & ~beatLast));
    strobe.loadPrio = ~lockNext;                 // R8
    holdIdx = lockIdxQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lockQ    <= 1'b0;
      lockIdxQ <= '0;
    end else begin
      lockQ <= lockNext;
      if (!lockQ && lockNext) lockIdxQ <= winIdx;
    end
  end
endmodule

// File: rtl/arbDatapath.sv
module arbDatapath
  import arb_pkg::*;
#(
  parameter int N = 4,
  parameter int PRIO_W = 2,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1,
  localparam int NG = 1 << PRIO_W
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [N-1:0]        reqVec,
  input  logic [N*PRIO_W-1:0] prioIn,
  input  ctrlStrobe_t         strobe,
  input  logic [IDX_W-1:0]    holdIdx,
  output logic [N-1:0]        grant,
  output logic [IDX_W-1:0]    winIdx,
  output logic                anyGrant
);
  logic [PRIO_W-1:0] prioQ [N];
  logic [IDX_W-1:0]  ptrQ  [NG];
  logic [PRIO_W-1:0] minPrio;
  logic [N-1:0]      eligible;
  logic              winValid;
  logic [IDX_W-1:0]  grantIdx;

  // smallest held priority among requesters (R3)
  always_comb begin
    minPrio = '1;
    for (int i = 0; i < N; i++)
      if (reqVec[i] && prioQ[i] < minPrio) minPrio = prioQ[i];
    for (int i = 0; i < N; i++)
      eligible[i] = reqVec[i] && (prioQ[i] == minPrio);
  end

  // rotating scan from the group pointer (R4)
  always_comb begin
    winIdx   = '0;
    winValid = 1'b0;
    for (int off = 0; off < N; off++) begin
      int cand;
      cand = int'(ptrQ[minPrio]) + off;
      if (cand >= N) cand = cand - N;
      if (!winValid && eligible[cand]) begin
        winValid = 1'b1;
        winIdx   = IDX_W'(cand);
      end
    end
  end

  always_comb begin
    grantIdx = strobe.hold ? holdIdx : winIdx;
    anyGrant = strobe.hold | winValid;
    grant    = '0;
    if (anyGrant) grant[grantIdx] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int g = 0; g < NG; g++) ptrQ[g] <= '0;
    end else if (strobe.advance) begin
      ptrQ[prioQ[grantIdx]] <= (grantIdx == IDX_W'(N - 1)) ? '0 : grantIdx + 1'b1;
    end
  end

  generate
    for (genvar i = 0; i < N; i++) begin : gPrio
      always_ff @(posedge clk) begin
        if (!rstN) prioQ[i] <= '1;             // R1: lowest priority
        else if (strobe.loadPrio) prioQ[i] <= prioIn[i*PRIO_W +: PRIO_W];
      end
    end
  endgenerate
endmodule

// File: rtl/grp_rr_arbiter.sv
module grp_rr_arbiter
  import arb_pkg::*;
#(
  parameter int N = 4,
  parameter int PRIO_W = 2,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [N-1:0]        reqVec,
  input  logic [N*PRIO_W-1:0] prioVec,
  input  logic                burstMode,
  input  logic                beatValid,
  input  logic                beatLast,
  output logic [N-1:0]        grant
);
  ctrlStrobe_t      strobe;
  logic [IDX_W-1:0] holdIdx, winIdx;
  logic             anyGrant;

  arbCtrl #(.N(N)) uCtrl (
    .clk(clk), .rstN(rstN), .burstMode(burstMode), .beatValid(beatValid),
    .beatLast(beatLast), .anyGrant(anyGrant), .winIdx(winIdx),
    .strobe(strobe), .holdIdx(holdIdx)
  );

  arbDatapath #(.N(N), .PRIO_W(PRIO_W)) uDp (
    .clk(clk), .rstN(rstN), .reqVec(reqVec), .prioIn(prioVec),
    .strobe(strobe), .holdIdx(holdIdx), .grant(grant),
    .winIdx(winIdx), .anyGrant(anyGrant)
  );
endmodule

// File: rtl/arbChecker.sv
module arbChecker #(
  parameter int N = 4
) (
  input logic         clk,
  input logic         rstN,
  input logic [N-1:0] reqVec,
  input logic         burstMode,
  input logic         beatValid,
  input logic         beatLast,
  input logic         holdNow,
  input logic [N-1:0] grant
);
  AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(grant)); // R2
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (!holdNow && reqVec == '0) |-> grant == '0); // R2
  AST_GRANT_REQUESTER: assert property (@(posedge clk) disable iff (!rstN)
    (!holdNow && grant != '0) |-> (grant & reqVec) == grant); // R3
  AST_BURST_LOCK: assert property (@(posedge clk) disable iff (!rstN)
    (burstMode && !holdNow && beatValid && !beatLast && grant != '0) |=> grant == $past(grant)); // R6
  AST_HELD_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (holdNow && !(beatValid && beatLast)) |=> grant == $past(grant)); // R6
  AST_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    (holdNow && beatValid && beatLast) |=> !holdNow); // R6
  AST_SINGLE_BEAT: assert property (@(posedge clk) disable iff (!rstN)
    (!holdNow && beatValid && beatLast) |=> !holdNow); // R7
  AST_BEAT_MODE: assert property (@(posedge clk) disable iff (!rstN)
    (!burstMode && !holdNow) |=> !holdNow); // R5
endmodule

bind grp_rr_arbiter arbChecker #(.N(N)) uChk (
  .clk(clk), .rstN(rstN), .reqVec(reqVec), .burstMode(burstMode),
  .beatValid(beatValid), .beatLast(beatLast), .holdNow(strobe.hold),
  .grant(grant)
);

// File: tb/sim_grp_rr_arbiter.sv
`timescale 1ns/1ps
module sim_grp_rr_arbiter;
  localparam int N = 4;
  localparam int PW = 2;
  localparam int NG = 1 << PW;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [N-1:0]  reqVec = '0;
  logic [N*PW-1:0] prioVec = '1;
  logic          burstMode = 1'b0, beatValid = 1'b0, beatLast = 1'b0;
  logic [N-1:0]  grant;

  int vectors = 0, miscompares = 0;
  bit done = 0;

  int mPrio [N];
  int mPtr  [NG];
  bit mLock;
  int mLockIdx;

  always #10 clk = ~clk;  // 50 MHz

  grp_rr_arbiter #(.N(N), .PRIO_W(PW)) u0 (
    .clk(clk), .rstN(rstN), .reqVec(reqVec), .prioVec(prioVec),
    .burstMode(burstMode), .beatValid(beatValid), .beatLast(beatLast),
    .grant(grant)
  );

  function automatic int expIdx();
    int minP = NG - 1;
    bit any = 0;
    if (mLock) return mLockIdx;
    for (int i = 0; i < N; i++)
      if (reqVec[i]) begin
        any = 1;
        if (mPrio[i] < minP) minP = mPrio[i];
      end
    if (!any) return -1;
    for (int off = 0; off < N; off++) begin
      int c = (mPtr[minP] + off) % N;
      if (reqVec[c] && mPrio[c] == minP) return c;
    end
    return -1;
  endfunction

  function automatic logic [N-1:0] toGrant(int idx);
    logic [N-1:0] g = '0;
    if (idx >= 0) g[idx] = 1'b1;
    return g;
  endfunction

  function automatic void modelReset();
    for (int i = 0; i < N; i++) mPrio[i] = NG - 1;
    for (int g = 0; g < NG; g++) mPtr[g] = 0;
    mLock = 0;
    mLockIdx = 0;
  endfunction

  function automatic void modelEdge(int idx);
    bit fire = beatValid && (idx >= 0);
    bit adv = 0;
    if (mLock) begin
      if (fire && beatLast) begin mLock = 0; adv = 1; end
    end else if (fire) begin
      if (burstMode && !beatLast) begin mLock = 1; mLockIdx = idx; end
      else adv = 1;
    end
    if (adv) mPtr[mPrio[idx]] = (idx + 1) % N;
    if (!mLock)
      for (int i = 0; i < N; i++) mPrio[i] = int'(prioVec[i*PW +: PW]);
  endfunction

  task automatic step(input logic [N-1:0] r, input logic [N*PW-1:0] p,
                      input logic bm, input logic bv, input logic bl,
                      input string tag);
    int idx;
    logic [N-1:0] exp;
    @(negedge clk);
    reqVec = r; prioVec = p; burstMode = bm; beatValid = bv; beatLast = bl;
    #2;
    idx = expIdx();
    exp = toGrant(idx);
    vectors++;
    if (grant !== exp) begin
      miscompares++;
      $display("FAIL %s: grant=%b expected=%b", tag, grant, exp);
    end
    @(posedge clk);
    modelEdge(idx);
  endtask

  function automatic string autoTag(logic [N-1:0] r);
    int minP = NG - 1, cnt = 0;
    if (mLock) return "R6";
    if (r == '0) return "R2";
    for (int i = 0; i < N; i++) if (r[i] && mPrio[i] < minP) minP = mPrio[i];
    for (int i = 0; i < N; i++) if (r[i] && mPrio[i] == minP) cnt++;
    return (cnt > 1) ? "R4" : "R3";
  endfunction

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: expired, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin : stim
    logic [N-1:0] r;
    logic [N*PW-1:0] p;
    logic bm;
    void'($urandom(32'd4711));
    modelReset();
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;

    // R1: reset state, all priorities lowest
    step('0, '1, 0, 0, 0, "R1");
    step(4'b1111, 8'b11_00_11_11, 0, 0, 0, "R1");   // held prio still all 3
    step(4'b1111, 8'b11_00_11_11, 0, 0, 0, "R8");   // master 2 now wins
    // R3: distinct priorities
    step(4'b1111, 8'b00_01_10_11, 0, 0, 0, "R8");
    step(4'b1111, 8'b00_01_10_11, 0, 0, 0, "R3");
    step(4'b0111, 8'b00_01_10_11, 0, 0, 0, "R3");
    // R5: beat mode alternation among equal group
    for (int k = 0; k < 5; k++) step(4'b0011, 8'b01_01_01_01, 0, 1, 0, "R5");
    // R10: no beat, no rotation
    for (int k = 0; k < 3; k++) step(4'b0011, 8'b01_01_01_01, 0, 0, 0, "R10");
    // R9: beat with nothing granted
    step('0, 8'b01_01_01_01, 0, 1, 1, "R9");
    step(4'b0011, 8'b01_01_01_01, 0, 0, 0, "R9");
    // R6 + R8: burst lock, priorities change mid-burst
    step(4'b1111, 8'b10_10_10_10, 1, 1, 0, "R6");
    step(4'b1000, 8'b00_11_11_11, 1, 0, 0, "R6");
    step(4'b1000, 8'b00_11_11_11, 1, 1, 0, "R8");
    step(4'b0000, 8'b00_11_11_11, 1, 0, 1, "R6");
    step(4'b1111, 8'b00_11_11_11, 1, 1, 1, "R6");
    step(4'b1111, 8'b00_11_11_11, 1, 0, 0, "R8");
    // R7: single-beat bursts rotate
    for (int k = 0; k < 4; k++) step(4'b0111, 8'b11_10_10_10, 1, 1, 1, "R7");
    // R4: wrap of pointer at the top index
    for (int k = 0; k < 6; k++) step(4'b1001, 8'b00_11_11_00, 0, 1, 1, "R4");

    // constrained random
    for (int k = 0; k < 4000; k++) begin
      r = N'($urandom);
      p = ($urandom_range(0, 3) == 0) ? (N*PW)'($urandom) : prioVec;
      bm = ($urandom_range(0, 15) == 0) ? ~burstMode : burstMode;
      step(r, p, bm, ($urandom_range(0, 3) != 0), ($urandom_range(0, 2) == 0), autoTag(r));
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule